// File: doc/BRIEF.md
# Interrupt Throttling Cause Controller

This block gathers interrupt causes from a network controller into a pending-cause register. It gates them through a mask register and drives one level interrupt line to the host. A throttle interval register sets a minimum spacing between posted interrupts. One unit of the interval is 256 ns. A free-running cycle counter converts the interval to clock cycles, using a ns-per-cycle parameter. Spacing is measured from the last interrupt that was actually posted. A cause that arrives inside the window arms one deferred post, due at the end of that window. A cause flagged urgent, such as a receive overrun, bypasses the window.

Posting sets an asserted flag, which sits one bit above the cause bits, and raises the line. At the same moment, every delay timer still running is cancelled through a strobe vector. Each cancelled timer folds its cause into the register: receive timers set the receive-timer bit and transmit timers set the transmit-done bit. Writing the mask register can retract an asserted line, or start a post. Reading the cause register clears it. A write-one-to-clear register path stands in for the host bus.

Top module: `itc_throttle_ctrl`

## Requirements
- R1: After reset, the cause vector (bits 7:0 causes, bit 8 asserted flag), the mask, the interval and the cancel strobes are all zero, and the line is low.
- R2: A cause pulse on a bit that is already pending, with urgent low, is ignored. It neither sets the line nor starts a post.
- R3: With an interval of zero, an accepted cause whose bit is enabled in the mask raises the line on the next clock edge. At that edge the asserted flag (bit 8) is also set.
- R4: An accepted cause with urgent high posts at the next edge, even inside the throttle window.
- R5: A non-urgent cause accepted fewer than interval×256/NS_PER_CYCLE cycles after the last post arms a deferred post. That post fires in the cycle whose counter value equals last post + interval×256/NS_PER_CYCLE. Only one deferred post is armed at a time.
- R6: A non-urgent cause accepted once the interval has elapsed since the last post posts at the next edge.
- R7: When a post is attempted while cause AND mask is zero, the line stays low and the flag stays clear.
- R8: A post pulses the cancel strobe for exactly the timers that are running, on the same edge that raises the line. Running receive timers (indices 0,1) set cause bit 7. Running transmit timers (indices 2,3) set cause bit 0.
- R9: A write to the mask register (address 0) that leaves cause AND mask zero drops the line and clears the flag at the next edge. It also cancels any armed deferred post.
- R10: A mask write that leaves cause AND mask nonzero posts at the next edge when the interval is zero. Otherwise it arms a deferred post due at the current count + interval×256/NS_PER_CYCLE, unless one is already armed.
- R11: A read strobe clears all cause bits and the flag, which drops the line.
- R12: An expiry pulse from timer 0 or 1 raises cause bit 7, and one from timer 2 or 3 raises cause bit 0. Each goes through the normal non-urgent cause path.
- R13: A write to address 2 clears every cause or flag bit (bits 8:0) set in the write data. The interval register is at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_pulse_i | input | CAUSE_W | One-cycle cause pulses |
| cause_urgent_i | input | 1 | Marks this cycle's cause pulses as urgent |
| tmr_exp_i | input | NUM_TMR | Delay-timer expiry pulses |
| tmr_run_i | input | NUM_TMR | Delay timers currently running |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 interval, 2 cause clear |
| reg_wdata_i | input | DATA_W | Register write data |
| cause_rd_i | input | 1 | Cause register read strobe (clears it) |
| irq_o | output | 1 | Interrupt line to the host |
| cause_o | output | CAUSE_W+1 | Pending causes, asserted flag on top |
| tmr_cancel_o | output | NUM_TMR | Cancel strobes to the delay timers |

## Verification
Every result is registered, so the effect of a stimulus held across one rising edge shows up after that edge. This holds for a cause pulse, a register write, a read strobe and a timer expiry, and covers cause bits, the line and cancel strobes alike. A deferred post is due in the cycle whose counter equals its deadline, and the line rises at the end of that cycle. The bench drives inputs on the falling edge and samples on the next falling edge. It keeps a cycle count that tracks the design's counter, which lets it compute each deadline from the interval and the recorded last-post cycle. It then checks the line low one cycle before the deadline and high right after.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int TIME_W  = 32;
    localparam int UNIT_NS = 256;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_ITV  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              armed;
        logic [TIME_W-1:0] due;
        logic [TIME_W-1:0] last;
    } thr_state_t;

    function automatic logic [TIME_W-1:0] units_to_cycles(
        input logic [TIME_W-1:0] units,
        input int unsigned       per_unit
    );
        return units * TIME_W'(per_unit);
    endfunction

endpackage

// File: rtl/itc_timebase.sv
module itc_timebase
    import itc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] now_o
);
    logic [TIME_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign now_o = cnt_q;
endmodule

// File: rtl/itc_cause_filter.sv
module itc_cause_filter #(
    parameter int CAUSE_W = 8,
    parameter int NUM_TMR = 4,
    parameter int RX_BIT  = 7,
    parameter int TX_BIT  = 0
) (
    input  logic [CAUSE_W-1:0] pulse_i,
    input  logic               urgent_i,
    input  logic [NUM_TMR-1:0] exp_i,
    input  logic [CAUSE_W-1:0] pending_i,
    output logic [CAUSE_W-1:0] accepted_o,
    output logic               urgent_o
);
    localparam int HALF = NUM_TMR / 2;

    logic [CAUSE_W-1:0] exp_bits;

    always_comb begin
        exp_bits = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (exp_i[i]) exp_bits[(i < HALF) ? RX_BIT : TX_BIT] = 1'b1;
        end
    end

    // urgent pulses pass even if pending; everything else only if new
    assign accepted_o = (urgent_i ? pulse_i : '0) | ((pulse_i | exp_bits) & ~pending_i);
    assign urgent_o   = urgent_i && (|pulse_i);
endmodule

// File: rtl/itc_timer_flush.sv
module itc_timer_flush #(
    parameter int CAUSE_W = 8,
    parameter int NUM_TMR = 4,
    parameter int RX_BIT  = 7,
    parameter int TX_BIT  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_TMR-1:0] run_i,
    input  logic               post_i,
    output logic [CAUSE_W-1:0] fold_o,
    output logic [NUM_TMR-1:0] cancel_o
);
    localparam int HALF = NUM_TMR / 2;

    logic rx_any;
    logic tx_any;

    assign rx_any = |run_i[HALF-1:0];
    assign tx_any = |run_i[NUM_TMR-1:HALF];

    always_comb begin
        fold_o         = '0;
        fold_o[RX_BIT] = rx_any;
        fold_o[TX_BIT] = fold_o[TX_BIT] | tx_any;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_cancel
        logic stb_q;
        always_ff @(posedge clk) begin
            if (rst) stb_q <= 1'b0;
            else     stb_q <= post_i && run_i[g];
        end
        assign cancel_o[g] = stb_q;
    end
endmodule

// File: rtl/itc_throttle_ctrl.sv
module itc_throttle_ctrl
    import itc_pkg::*;
#(
    parameter int CAUSE_W      = 8,
    parameter int NUM_TMR      = 4,
    parameter int ITV_W        = 16,
    parameter int DATA_W       = 16,
    parameter int NS_PER_CYCLE = 8,
    parameter int RX_BIT       = 7,
    parameter int TX_BIT       = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] cause_pulse_i,
    input  logic               cause_urgent_i,
    input  logic [NUM_TMR-1:0] tmr_exp_i,
    input  logic [NUM_TMR-1:0] tmr_run_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic               cause_rd_i,
    output logic               irq_o,
    output logic [CAUSE_W:0]   cause_o,
    output logic [NUM_TMR-1:0] tmr_cancel_o
);
    localparam int CYC_PER_UNIT = UNIT_NS / NS_PER_CYCLE;
    localparam int FLAG         = CAUSE_W;

    logic [CAUSE_W:0]   cause_q, cause_n, cleared;
    logic [CAUSE_W-1:0] mask_q, mask_n;
    logic [ITV_W-1:0]   itv_q, itv_n;
    thr_state_t         thr_q, thr_n;
    logic [TIME_W-1:0]  now, itv_cyc, elapsed;
    logic [CAUSE_W-1:0] accepted, fold;
    logic               urg, want, post_go;
    logic               wr_mask, wr_itv, wr_clr;
    reg_sel_e           sel;

    assign sel     = reg_sel_e'(reg_addr_i);
    assign wr_mask = reg_wr_i && (sel == SEL_MASK);
    assign wr_itv  = reg_wr_i && (sel == SEL_ITV);
    assign wr_clr  = reg_wr_i && (sel == SEL_CLR);

    itc_timebase u_time (.clk(clk), .rst(rst), .now_o(now));

    always_comb begin
        cleared = cause_rd_i ? '0 : cause_q;
        if (wr_clr) cleared = cleared & ~reg_wdata_i[CAUSE_W:0];
    end

    assign mask_n  = wr_mask ? reg_wdata_i[CAUSE_W-1:0] : mask_q;
    assign itv_n   = wr_itv  ? reg_wdata_i[ITV_W-1:0]   : itv_q;
    assign itv_cyc = units_to_cycles(TIME_W'(itv_n), CYC_PER_UNIT);
    assign elapsed = now - thr_q.last;

    itc_cause_filter #(
        .CAUSE_W(CAUSE_W), .NUM_TMR(NUM_TMR), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
    ) u_filter (
        .pulse_i   (cause_pulse_i),
        .urgent_i  (cause_urgent_i),
        .exp_i     (tmr_exp_i),
        .pending_i (cleared[CAUSE_W-1:0]),
        .accepted_o(accepted),
        .urgent_o  (urg)
    );

    itc_timer_flush #(
        .CAUSE_W(CAUSE_W), .NUM_TMR(NUM_TMR), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
    ) u_flush (
        .clk     (clk),
        .rst     (rst),
        .run_i   (tmr_run_i),
        .post_i  (post_go),
        .fold_o  (fold),
        .cancel_o(tmr_cancel_o)
    );

    always_comb begin
        cause_n = cleared;
        thr_n   = thr_q;
        want    = 1'b0;

        // deferred post reaches its deadline
        if (thr_q.armed && (now == thr_q.due)) begin
            want        = 1'b1;
            thr_n.armed = 1'b0;
        end

        // new causes: immediate or throttled
        if (|accepted) begin
            cause_n[CAUSE_W-1:0] = cause_n[CAUSE_W-1:0] | accepted;
            if ((itv_n == '0) || urg || (elapsed >= itv_cyc)) begin
                want = 1'b1;
            end else if (!thr_n.armed) begin
                thr_n.armed = 1'b1;
                thr_n.due   = thr_q.last + itv_cyc;
            end
        end

        // mask update re-evaluates the line
        if (wr_mask) begin
            if ((cause_n[CAUSE_W-1:0] & mask_n) == '0) begin
                thr_n.armed   = 1'b0;
                cause_n[FLAG] = 1'b0;
            end else if (itv_n == '0) begin
                want = 1'b1;
            end else if (!thr_n.armed) begin
                thr_n.armed = 1'b1;
                thr_n.due   = now + itv_cyc;
            end
        end

        post_go = want && ((cause_n[CAUSE_W-1:0] & mask_n) != '0);

        if (post_go) begin
            thr_n.armed          = 1'b0;
            cause_n[CAUSE_W-1:0] = cause_n[CAUSE_W-1:0] | fold;
            cause_n[FLAG]        = 1'b1;
            thr_n.last           = now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            itv_q   <= '0;
            thr_q   <= '0;
        end else begin
            cause_q <= cause_n;
            mask_q  <= mask_n;
            itv_q   <= itv_n;
            thr_q   <= thr_n;
        end
    end

    assign irq_o   = cause_q[FLAG];
    assign cause_o = cause_q;
endmodule

// File: rtl/itc_throttle_ctrl_chk.sv
module itc_throttle_ctrl_chk #(
    parameter int CAUSE_W = 8,
    parameter int NUM_TMR = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic [CAUSE_W:0]   cause_o,
    input logic [NUM_TMR-1:0] tmr_cancel_o,
    input logic [NUM_TMR-1:0] tmr_run_i,
    input logic [NUM_TMR-1:0] tmr_exp_i,
    input logic [CAUSE_W-1:0] cause_pulse_i,
    input logic               reg_wr_i,
    input logic [1:0]         reg_addr_i,
    input logic [CAUSE_W-1:0] wdata_lo,
    input logic               cause_rd_i,
    input logic [CAUSE_W-1:0] mask_q
);
    // R1: state right after reset release
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cause_o == '0 && !irq_o && tmr_cancel_o == '0));

    // R7: the line only rises with an enabled cause pending
    a_r7_rise_needs_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ((cause_o[CAUSE_W-1:0] & mask_q) != '0));

    // R8: cancel strobes come with a post, only for timers that were running
    a_r8_cancel_with_post: assert property (@(posedge clk) disable iff (rst)
        (tmr_cancel_o != '0) |-> irq_o);
    a_r8_cancel_subset: assert property (@(posedge clk) disable iff (rst)
        (tmr_cancel_o & ~$past(tmr_run_i)) == '0);

    // R9: a mask write with no overlap retracts the line
    a_r9_mask_retract: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == 2'd0 && !cause_rd_i && cause_pulse_i == '0 &&
         tmr_exp_i == '0 && ((cause_o[CAUSE_W-1:0] & wdata_lo) == '0)) |=> !irq_o);

    // R11: a read with nothing arriving leaves the register empty
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (cause_rd_i && !reg_wr_i && cause_pulse_i == '0 && tmr_exp_i == '0)
        |=> (cause_o == '0 && !irq_o));
endmodule

bind itc_throttle_ctrl itc_throttle_ctrl_chk #(
    .CAUSE_W(CAUSE_W), .NUM_TMR(NUM_TMR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_o        (irq_o),
    .cause_o      (cause_o),
    .tmr_cancel_o (tmr_cancel_o),
    .tmr_run_i    (tmr_run_i),
    .tmr_exp_i    (tmr_exp_i),
    .cause_pulse_i(cause_pulse_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .wdata_lo     (reg_wdata_i[CAUSE_W-1:0]),
    .cause_rd_i   (cause_rd_i),
    .mask_q       (mask_q)
);

// File: tb/tb_itc_throttle_ctrl.sv
module tb_itc_throttle_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_UNIT   = 32;   // 256 ns at 8 ns per cycle

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pul = '0;
    logic        urg = 1'b0;
    logic [3:0]  exp_v = '0;
    logic [3:0]  run = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wd = '0;
    logic        rd = 1'b0;
    logic        irq;
    logic [8:0]  cause;
    logic [3:0]  cancel;

    int nchk = 0;
    int nerr = 0;

    // reference state
    logic [8:0]  m_cause = '0;
    logic [7:0]  m_mask  = '0;
    logic [15:0] m_itv   = '0;
    logic        m_armed = 1'b0;
    logic [31:0] m_due   = '0;
    logic [31:0] m_last  = '0;
    logic [31:0] m_now   = '0;
    logic [3:0]  e_cancel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    itc_throttle_ctrl dut (
        .clk(clk), .rst(rst), .cause_pulse_i(pul), .cause_urgent_i(urg),
        .tmr_exp_i(exp_v), .tmr_run_i(run), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wd), .cause_rd_i(rd), .irq_o(irq), .cause_o(cause),
        .tmr_cancel_o(cancel)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // one clock cycle: drive at falling edge, predict, sample at next falling edge
    task automatic step(input string tag, input logic [7:0] p, input logic u,
                        input logic [3:0] e, input logic [3:0] r, input logic w,
                        input logic [1:0] a, input logic [15:0] d, input logic rdv);
        logic [8:0]  c;
        logic [7:0]  mk, expb, acc, fold;
        logic [15:0] iv;
        logic [31:0] ic;
        logic        want, arm, go, uu;
        logic [31:0] due;
        pul = p; urg = u; exp_v = e; run = r; wr = w; addr = a; wd = d; rd = rdv;
        c = rdv ? 9'h0 : m_cause;
        if (w && a == 2'd2) c = c & ~d[8:0];
        mk = (w && a == 2'd0) ? d[7:0] : m_mask;
        iv = (w && a == 2'd1) ? d : m_itv;
        ic = 32'(iv) * CYC_UNIT;
        want = 1'b0; arm = m_armed; due = m_due;
        if (m_armed && m_now == m_due) begin want = 1'b1; arm = 1'b0; end
        expb = '0;
        if (|e[1:0]) expb[7] = 1'b1;
        if (|e[3:2]) expb[0] = 1'b1;
        acc = (u ? p : 8'h0) | ((p | expb) & ~c[7:0]);
        uu = u && (p != 0);
        if (acc != 0) begin
            c[7:0] = c[7:0] | acc;
            if (iv == 0 || uu || (m_now - m_last) >= ic) want = 1'b1;
            else if (!arm) begin arm = 1'b1; due = m_last + ic; end
        end
        if (w && a == 2'd0) begin
            if ((c[7:0] & mk) == 0) begin arm = 1'b0; c[8] = 1'b0; end
            else if (iv == 0) want = 1'b1;
            else if (!arm) begin arm = 1'b1; due = m_now + ic; end
        end
        go = want && ((c[7:0] & mk) != 0);
        fold = '0;
        fold[7] = |r[1:0];
        fold[0] = |r[3:2];
        e_cancel = go ? r : 4'h0;
        if (go) begin arm = 1'b0; c[7:0] = c[7:0] | fold; c[8] = 1'b1; m_last = m_now; end
        m_cause = c; m_mask = mk; m_itv = iv; m_armed = arm; m_due = due;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "cause", 32'(cause), 32'(m_cause));
        chk(tag, "irq", 32'(irq), 32'(m_cause[8]));
        chk(tag, "cancel", 32'(cancel), 32'(e_cancel));
        m_now = m_now + 1;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 8'h0, 1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 16'h0, 1'b0);
    endtask
    task automatic pulse(input string tag, input logic [7:0] p, input logic u);
        step(tag, p, u, 4'h0, 4'h0, 1'b0, 2'd0, 16'h0, 1'b0);
    endtask
    task automatic wreg(input string tag, input logic [1:0] a, input logic [15:0] d);
        step(tag, 8'h0, 1'b0, 4'h0, 4'h0, 1'b1, a, d, 1'b0);
    endtask
    task automatic rdclr(input string tag);
        step(tag, 8'h0, 1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 16'h0, 1'b1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] dl;
        logic [3:0]  hold_run;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "cause", 32'(cause), 32'h0);
        chk("R1", "irq", 32'(irq), 32'h0);
        chk("R1", "cancel", 32'(cancel), 32'h0);

        // R3: zero interval, enabled cause posts next edge
        wreg("R10", 2'd0, 16'h000F);
        pulse("R3", 8'h02, 1'b0);
        chk("R3", "cause literal", 32'(cause), 32'h102);
        // R11: read clears
        rdclr("R11");
        chk("R11", "cause literal", 32'(cause), 32'h0);
        // R7: masked cause does not assert
        pulse("R7", 8'h20, 1'b0);
        chk("R7", "cause literal", 32'(cause), 32'h020);
        chk("R7", "irq literal", 32'(irq), 32'h0);
        rdclr("R11");

        // R6: interval elapsed -> immediate
        wreg("R13", 2'd1, 16'd2);
        idle("R6", 70);
        pulse("R6", 8'h04, 1'b0);
        chk("R6", "irq literal", 32'(irq), 32'h1);
        rdclr("R11");
        // R5: inside window -> deferred to last + 2 units
        pulse("R5", 8'h08, 1'b0);
        chk("R5", "irq deferred", 32'(irq), 32'h0);
        dl = m_last + 32'(2 * CYC_UNIT);
        while (m_now != dl) idle("R5", 1);
        chk("R5", "irq before deadline", 32'(irq), 32'h0);
        idle("R5", 1);
        chk("R5", "irq at deadline", 32'(irq), 32'h1);
        rdclr("R11");

        // R4: urgent bypasses the window
        pulse("R4", 8'h02, 1'b1);
        chk("R4", "irq literal", 32'(irq), 32'h1);
        // R13: clear only the flag
        wreg("R13", 2'd2, 16'h0100);
        chk("R13", "cause literal", 32'(cause), 32'h002);
        wreg("R3", 2'd1, 16'd0);
        // R2: already pending, non-urgent -> ignored
        pulse("R2", 8'h02, 1'b0);
        chk("R2", "irq literal", 32'(irq), 32'h0);
        pulse("R4", 8'h02, 1'b1);
        chk("R4", "irq urgent pending", 32'(irq), 32'h1);
        rdclr("R11");

        // R8: post flushes running timers
        step("R8", 8'h02, 1'b0, 4'h0, 4'b0101, 1'b0, 2'd0, 16'h0, 1'b0);
        chk("R8", "cause literal", 32'(cause), 32'h183);
        chk("R8", "cancel literal", 32'(cancel), 32'h5);
        rdclr("R11");

        // R12: timer expiries as causes
        step("R12", 8'h0, 1'b0, 4'b0010, 4'h0, 1'b0, 2'd0, 16'h0, 1'b0);
        chk("R12", "rx expiry literal", 32'(cause), 32'h080);
        step("R12", 8'h0, 1'b0, 4'b1000, 4'h0, 1'b0, 2'd0, 16'h0, 1'b0);
        chk("R12", "tx expiry literal", 32'(cause), 32'h181);
        rdclr("R11");

        // R9: mask write retracts line
        pulse("R3", 8'h02, 1'b0);
        wreg("R9", 2'd0, 16'h0040);
        chk("R9", "irq retract", 32'(irq), 32'h0);
        // R10: overlap with zero interval posts
        wreg("R10", 2'd0, 16'h0002);
        chk("R10", "irq literal", 32'(irq), 32'h1);

        // R9: mask write cancels armed deferred post
        rdclr("R11");
        wreg("R9", 2'd0, 16'h000F);
        wreg("R13", 2'd1, 16'd3);
        pulse("R5", 8'h04, 1'b0);
        wreg("R9", 2'd0, 16'h0030);
        idle("R9", 110);
        chk("R9", "armed post cancelled", 32'(irq), 32'h0);

        // R10: overlap with nonzero interval -> due now + interval
        wreg("R13", 2'd1, 16'd1);
        dl = m_now + 32'(CYC_UNIT);
        wreg("R10", 2'd0, 16'h0004);
        chk("R10", "irq deferred", 32'(irq), 32'h0);
        while (m_now != dl) idle("R10", 1);
        chk("R10", "irq before deadline", 32'(irq), 32'h0);
        idle("R10", 1);
        chk("R10", "irq at deadline", 32'(irq), 32'h1);
        rdclr("R11");

        // R13: write-one-to-clear of cause bits
        wreg("R13", 2'd0, 16'h0000);
        pulse("R13", 8'h06, 1'b0);
        wreg("R13", 2'd2, 16'h0002);
        chk("R13", "cause literal", 32'(cause), 32'h004);
        rdclr("R11");

        // random mix against the reference
        hold_run = '0;
        for (int n = 0; n < 2500; n++) begin
            logic [7:0]  p;
            logic        u, w, rdv;
            logic [3:0]  e;
            logic [1:0]  a;
            logic [15:0] d;
            if (n % 20 == 0) hold_run = 4'($urandom % 16);
            p   = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
            u   = ($urandom % 8 == 0);
            e   = ($urandom % 10 == 0) ? 4'($urandom % 16) : 4'h0;
            w   = ($urandom % 12 == 0);
            a   = 2'($urandom % 3);
            d   = (a == 2'd1) ? 16'($urandom % 4) : 16'($urandom);
            rdv = ($urandom % 10 == 0);
            step("R5", p, u, e, hold_run, w, a, d, rdv);
        end

        finish_run();
    end
endmodule